// File: doc/BRIEF.md
# NAND Command Descriptor Loader

This block is the command-buffer part of the register file of a NAND flash controller. Software builds a command descriptor and pushes it one 32-bit word at a time, always to the same register address, the load port. An internal slot pointer sends each accepted word to the next command buffer register. On the base variant a descriptor has three words. On the extended variant it has four, and the fourth word holds a 16-bit transfer length. That length lets the engine run transfers whose size is not a standard page size.

The engine asks for a descriptor by pulsing `reqSet`. This raises a request flag in the status register, which software clears by writing 1 to it, and it opens a loading window. When the last word lands, the block pulses `descValid` for one cycle and presents the whole descriptor, plus the length field, to the engine. The window then closes until the next request. Every buffer can be read back at its own address, but only the load port writes into them.

Top module: `nand_cmd_loader`

Register addresses, as word addresses on `regAddr`: 0 = status (bit 0 = request flag, other bits read 0), 1 = load port / buffer 0, 2 = buffer 1, 3 = buffer 2, 4 = buffer 3, 5 to 7 = unmapped.

## Requirements
- R1: After a synchronous reset, all buffers read 0, the request flag reads 0, `descValid` is 0, `lenCount` is 0 and the slot pointer points at buffer 0.
- R2: A cycle with `reqSet` high sets status bit 0, resets the slot pointer to buffer 0 and opens the loading window.
- R3: A write to address 0 with data bit 0 set clears the request flag. Bit 0 clear leaves it unchanged. When `reqSet` falls in the same cycle as the clearing write, the flag stays set.
- R4: While the window is open, the 1st, 2nd, 3rd and 4th writes to address 1 are stored in buffers 0, 1, 2 and 3, in that order.
- R5: Writes to addresses 2, 3 and 4 change no buffer and do not move the slot pointer.
- R6: A write to address 1 while the window is closed, or in a cycle with `reqSet` high, is discarded.
- R7: The cycle after the clock edge that stores the final word (the 3rd on the base variant, the 4th on the extended one), `descValid` is 1 for exactly one cycle, with `descData` holding buffer n in bits [32n+31:32n]. The window then closes.
- R8: Reads return each buffer at its own address. On the base variant address 4 reads 0. Unmapped addresses read 0.
- R9: `lenCount` equals bits [15:0] of buffer 3 on the extended variant and is 0 on the base variant.
- R10: A `reqSet` in the middle of a descriptor restarts loading, so the next write to address 1 goes to buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| reqSet | input | 1 | Engine request for a new descriptor |
| descValid | output | 1 | One-cycle pulse: descriptor complete |
| descData | output | 128 | Descriptor words, buffer 0 in the low word |
| lenCount | output | 16 | Transfer length field of buffer 3 |

## Verification
A slot pointer that is off by one puts words in the wrong buffer, and read-back shows this on the next access. It also makes `descValid` come a write early or late, which is visible the cycle after the final write. A window that is wrongly open or closed shows as a buffer that changes after a stray write, or as a buffer that stays unchanged when it should have loaded, and the next read exposes either one. A request flag that fails to set or clear shows up on the following status read.

// File: rtl/ncl_pkg.sv
package ncl_pkg;
  localparam int SLOT_W = 2;
  localparam int MAX_SLOTS = 4;
  localparam logic [2:0] ADDR_STATUS = 3'd0;
  localparam logic [2:0] ADDR_CB0 = 3'd1;
  localparam logic [2:0] ADDR_CB1 = 3'd2;
  localparam logic [2:0] ADDR_CB2 = 3'd3;
  localparam logic [2:0] ADDR_CB3 = 3'd4;

  typedef struct packed {
    logic load;
    logic [SLOT_W-1:0] slot;
  } cbStrobe_t;
endpackage

// File: rtl/ncl_ctrl.sv
module ncl_ctrl
  import ncl_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic       regWrBit0,
  input  logic       reqSet,
  output cbStrobe_t  strobe,
  output logic       cmdReq,
  output logic       loadOpen,
  output logic       descValid
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_WORDS - 1);

  logic [SLOT_W-1:0] slotPtr;
  logic wrLoad;
  logic wrStatus;
  logic accept;
  logic lastWord;

  always_comb begin
    wrLoad   = regWrEn && (regAddr == ADDR_CB0);
    wrStatus = regWrEn && (regAddr == ADDR_STATUS);
    accept   = wrLoad && loadOpen && !reqSet;
    lastWord = (slotPtr == LAST_SLOT);
    strobe.load = accept;
    strobe.slot = slotPtr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotPtr   <= '0;
      loadOpen  <= 1'b0;
      cmdReq    <= 1'b0;
      descValid <= 1'b0;
    end else begin
      descValid <= accept && lastWord;
      if (reqSet) begin
        slotPtr  <= '0;
        loadOpen <= 1'b1;
        cmdReq   <= 1'b1;
      end else begin
        if (wrStatus && regWrBit0) begin
          cmdReq <= 1'b0;
        end
        if (accept) begin
          if (lastWord) begin
            slotPtr  <= '0;
            loadOpen <= 1'b0;
          end else begin
            slotPtr <= slotPtr + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ncl_dpath.sv
module ncl_dpath
  import ncl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEN_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  cbStrobe_t                     strobe,
  input  logic [WORD_W-1:0]             regWrData,
  input  logic [2:0]                    regAddr,
  input  logic                          cmdReq,
  output logic [WORD_W-1:0]             regRdData,
  output logic [MAX_SLOTS*WORD_W-1:0]   descData,
  output logic [LEN_W-1:0]              lenCount
);
  logic [WORD_W-1:0] cbReg [MAX_SLOTS];

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
    if (i < NUM_WORDS) begin : g_real
      always_ff @(posedge clk) begin
        if (rst) begin
          cbReg[i] <= '0;
        end else if (strobe.load && (strobe.slot == SLOT_W'(i))) begin
          cbReg[i] <= regWrData;
        end
      end
    end else begin : g_absent
      assign cbReg[i] = '0;
    end
    assign descData[i*WORD_W +: WORD_W] = cbReg[i];
  end

  assign lenCount = cbReg[MAX_SLOTS-1][LEN_W-1:0];

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_STATUS: regRdData[0] = cmdReq;
      ADDR_CB0:    regRdData = cbReg[0];
      ADDR_CB1:    regRdData = cbReg[1];
      ADDR_CB2:    regRdData = cbReg[2];
      ADDR_CB3:    regRdData = cbReg[3];
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/nand_cmd_loader.sv
module nand_cmd_loader
  import ncl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W = 16,
  parameter bit EXT_EN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  regAddr,
  input  logic                        regWrEn,
  input  logic [WORD_W-1:0]           regWrData,
  output logic [WORD_W-1:0]           regRdData,
  input  logic                        reqSet,
  output logic                        descValid,
  output logic [MAX_SLOTS*WORD_W-1:0] descData,
  output logic [LEN_W-1:0]            lenCount
);
  localparam int NUM_WORDS = EXT_EN ? 4 : 3;

  cbStrobe_t strobe;
  logic cmdReq;
  logic loadOpen;

  ncl_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrBit0 (regWrData[0]),
    .reqSet    (reqSet),
    .strobe    (strobe),
    .cmdReq    (cmdReq),
    .loadOpen  (loadOpen),
    .descValid (descValid)
  );

  ncl_dpath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .LEN_W(LEN_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regAddr   (regAddr),
    .cmdReq    (cmdReq),
    .regRdData (regRdData),
    .descData  (descData),
    .lenCount  (lenCount)
  );
endmodule

// File: rtl/ncl_checker.sv
module ncl_checker
  import ncl_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [2:0]                  regAddr,
  input logic                        regWrEn,
  input logic [WORD_W-1:0]           regWrData,
  input logic                        reqSet,
  input logic                        descValid,
  input logic [MAX_SLOTS*WORD_W-1:0] descData,
  input logic                        cmdReq,
  input logic                        loadOpen
);
  AST_REQ_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    reqSet |=> (cmdReq && loadOpen)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADDR_STATUS && regWrData[0] && !reqSet) |=> !cmdReq); // R3

  AST_NO_LOAD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr == ADDR_CB0) |=> $stable(descData)); // R5

  AST_CLOSED_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (!loadOpen && !reqSet) |=> $stable(descData)); // R6

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    descValid |=> !descValid); // R7

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(descValid) |-> ($past(regWrEn && regAddr == ADDR_CB0 && !reqSet) && !loadOpen)); // R7
endmodule

bind nand_cmd_loader ncl_checker #(.WORD_W(WORD_W)) u_ncl_checker (
  .clk       (clk),
  .rst       (rst),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .reqSet    (reqSet),
  .descValid (descValid),
  .descData  (descData),
  .cmdReq    (cmdReq),
  .loadOpen  (loadOpen)
);

// File: tb/test_nand_cmd_loader.sv
module test_nand_cmd_loader;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic reqSet = 1'b0;
  logic [31:0] rdExt, rdBase;
  logic dvExt, dvBase;
  logic [127:0] ddExt, ddBase;
  logic [15:0] lenExt, lenBase;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_loader #(.EXT_EN(1'b1)) i_nand_cmd_loader (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdExt), .reqSet(reqSet),
    .descValid(dvExt), .descData(ddExt), .lenCount(lenExt));

  nand_cmd_loader #(.EXT_EN(1'b0)) i_nand_cmd_loader_base (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdBase), .reqSet(reqSet),
    .descValid(dvBase), .descData(ddBase), .lenCount(lenBase));

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseReq();
    reqSet = 1'b1;
    @(negedge clk);
    reqSet = 1'b0;
  endtask

  task automatic rdExtChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    chk(req, $sformatf("ext read addr %0d", a), {96'd0, rdExt}, {96'd0, exp});
  endtask

  task automatic rdBaseChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    chk(req, $sformatf("base read addr %0d", a), {96'd0, rdBase}, {96'd0, exp});
  endtask

  task automatic t_reset();
    for (int a = 0; a < 5; a++) begin
      rdExtChk("R1", 3'(a), 32'd0);
      rdBaseChk("R1", 3'(a), 32'd0);
    end
    chk("R1", "descValid", {127'd0, dvExt}, 128'd0);
    chk("R1", "lenCount", {112'd0, lenExt}, 128'd0);
  endtask

  task automatic t_request();
    pulseReq();
    rdExtChk("R2", 3'd0, 32'd1);
    rdBaseChk("R2", 3'd0, 32'd1);
  endtask

  task automatic t_w1c();
    wr(3'd0, 32'hFFFF_FFFE);
    rdExtChk("R3", 3'd0, 32'd1);
    wr(3'd0, 32'h1);
    rdExtChk("R3", 3'd0, 32'd0);
    regAddr = 3'd0; regWrData = 32'h1; regWrEn = 1'b1; reqSet = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; reqSet = 1'b0;
    rdExtChk("R3", 3'd0, 32'd1);
  endtask

  task automatic t_full_load(input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input logic [31:0] w3);
    pulseReq();
    wr(3'd1, w0);
    wr(3'd1, w1);
    chk("R7", "no early valid", {126'd0, dvExt, dvBase}, 128'd0);
    wr(3'd1, w2);
    chk("R7", "base valid after 3rd", {127'd0, dvBase}, 128'd1);
    chk("R7", "ext not valid after 3rd", {127'd0, dvExt}, 128'd0);
    chk("R7", "base descData", ddBase, {32'd0, w2, w1, w0});
    wr(3'd1, w3);
    chk("R7", "ext valid after 4th", {127'd0, dvExt}, 128'd1);
    chk("R7", "base valid drops", {127'd0, dvBase}, 128'd0);
    chk("R7", "ext descData", ddExt, {w3, w2, w1, w0});
    chk("R9", "ext lenCount", {112'd0, lenExt}, {112'd0, w3[15:0]});
    chk("R9", "base lenCount", {112'd0, lenBase}, 128'd0);
    @(negedge clk);
    chk("R7", "ext valid one cycle", {127'd0, dvExt}, 128'd0);
    rdExtChk("R4", 3'd1, w0);
    rdExtChk("R4", 3'd2, w1);
    rdExtChk("R4", 3'd3, w2);
    rdExtChk("R4", 3'd4, w3);
    rdBaseChk("R8", 3'd3, w2);
    rdBaseChk("R8", 3'd4, 32'd0);
    rdExtChk("R8", 3'd5, 32'd0);
    rdExtChk("R8", 3'd7, 32'd0);
  endtask

  task automatic t_closed();
    wr(3'd1, 32'hBAD0_0001);
    rdExtChk("R6", 3'd1, 32'h1111_0000);
    chk("R6", "no valid when closed", {127'd0, dvExt}, 128'd0);
    regAddr = 3'd1; regWrData = 32'hBAD0_0002; regWrEn = 1'b1; reqSet = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; reqSet = 1'b0;
    rdExtChk("R6", 3'd1, 32'h1111_0000);
  endtask

  task automatic t_direct();
    wr(3'd2, 32'hD1D1_D1D1);
    wr(3'd3, 32'hD2D2_D2D2);
    wr(3'd4, 32'hD3D3_D3D3);
    rdExtChk("R5", 3'd2, 32'h1111_0001);
    rdExtChk("R5", 3'd3, 32'h1111_0002);
    rdExtChk("R5", 3'd4, 32'h1111_0003);
    wr(3'd1, 32'h5555_0000);
    rdExtChk("R5", 3'd1, 32'h5555_0000);
    rdExtChk("R5", 3'd2, 32'h1111_0001);
  endtask

  task automatic t_restart();
    pulseReq();
    wr(3'd1, 32'hAAAA_0000);
    wr(3'd1, 32'hAAAA_0001);
    pulseReq();
    wr(3'd1, 32'hCCCC_0000);
    rdExtChk("R10", 3'd1, 32'hCCCC_0000);
    rdExtChk("R10", 3'd2, 32'hAAAA_0001);
    wr(3'd1, 32'hCCCC_0001);
    wr(3'd1, 32'hCCCC_0002);
    wr(3'd1, 32'hCCCC_0123);
    chk("R10", "valid after restart", {127'd0, dvExt}, 128'd1);
    chk("R10", "descData after restart", ddExt,
        {32'hCCCC_0123, 32'hCCCC_0002, 32'hCCCC_0001, 32'hCCCC_0000});
    chk("R9", "lenCount after restart", {112'd0, lenExt}, {112'd0, 16'h0123});
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_request();
        t_w1c();
        t_full_load(32'h1111_0000, 32'h1111_0001, 32'h1111_0002, 32'h1111_0003);
        t_closed();
        pulseReq();
        t_direct();
        t_restart();
        t_full_load(32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'h00AB_FFFF);
        done = 1;
      end
      begin
        repeat (5000) @(negedge clk);
      end
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule